// File: doc/BRIEF.md
# Variable-density MFM cell generator

This block turns a stream of track bytes into the raw pulse train that a floppy drive would put on its read-data line. Each data bit becomes two raw cells: a clock cell followed by a data cell. A 1 in a cell appears as a short active-low pulse at the start of that cell. The length of a cell is not fixed. Every byte carries its own density value, in thousandths of the nominal cell time. A track can therefore shrink or stretch its cells from one byte to the next, which is how copy-protected tracks are laid down. No gap or stall appears in the output when the density changes.

The nominal cell time is `NOM_TICKS` clock ticks. With the default 125 MHz tick, 250 ticks make a 2 µs raw cell, which is a 250 kbit/s data rate. A cell of density d lasts d·NOM_TICKS/1000 ticks. The fractional part of each cell length is carried into the next cell, so the long-run rate is exact. Bytes are taken through a valid/ready handshake, but only at a byte boundary. If no byte is offered at that moment, the generator fills the slot with silent cells and records the underrun. Clearing the enable stops the output at once and restarts the timing from scratch.

The encoder is a four-state machine:
- CELL_OFF is the state while disabled.
- CELL_CLOCK and CELL_DATA alternate for every bit of a byte.
- CELL_GAP covers a byte slot with no data.

Transitions:
- *start*: CELL_OFF to CELL_CLOCK or CELL_GAP, on the first load after enable.
- *bit half*: CELL_CLOCK to CELL_DATA.
- *next bit*: CELL_DATA to CELL_CLOCK.
- *byte boundary*: from the last cell of a slot to CELL_CLOCK if a byte is offered, otherwise to CELL_GAP.
- *stop*: any state to CELL_OFF when the enable is low.

Top module: `mfm_cell_gen`

## Requirements
- R1: With density 1000, every raw cell lasts exactly NOM_TICKS clock cycles. The cell length is measured as the spacing between `cell_stb` pulses.
- R2: A cell length is floor((density·NOM_TICKS + carry)/1000). The new carry is the remainder of that division. The carry starts at 0 when the block is enabled and is kept across density changes. A byte's density applies from the first cell of that byte.
- R3: Bytes are sent MSB first. Each data bit produces a clock cell and then a data cell. The data cell holds the bit. The clock cell holds 1 only when the previous data bit and this data bit are both 0.
- R4: `cell_stb` is high on exactly the first cycle of each cell. In a cell holding 1, `rd_n` is low for the first min(PULSE_TICKS, cell length) cycles of that cell. Otherwise `rd_n` is high.
- R5: While enabled, `in_ready` is high for one cycle per byte slot. That cycle is the last cycle before the slot's first cell, or the first enabled cycle after a disable. A byte transfers when `in_valid` and `in_ready` are both high.
- R6: A byte slot with `in_valid` low gives 16 cells of 0 at the last accepted density. The previous data bit is then taken as 0. `underrun` rises and stays high while the block remains enabled.
- R7: While `en` is low, `rd_n` is high and `cell_stb`, `in_ready` and `underrun` are low. The carry and the byte position are cleared. After re-enable, the previous data bit is taken as 0.
- R8: After reset, `rd_n` is high and `cell_stb`, `in_ready` and `underrun` are low. The held density is 1000.
- R9: A computed cell length of 0 is raised to 1 cycle. The remainder is still carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock, one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Generator enable |
| in_data | input | DATA_W | Track byte, MSB sent first |
| in_dens | input | DENS_W | Density of that byte, 1000 = nominal |
| in_valid | input | 1 | Byte and density are offered |
| in_ready | output | 1 | Byte boundary: offer is taken this cycle |
| rd_n | output | 1 | Active-low MFM pulse line |
| cell_stb | output | 1 | High in the first cycle of each raw cell |
| underrun | output | 1 | Sticky flag: a byte slot went empty |

## Verification
Several byte patterns are sent at nominal density:
- All zeros, which shows clock insertion between zero bits.
- All ones, which shows that no clock cell is placed between ones.
- Alternating and single-bit bytes, which show the boundaries between bytes and the carry of the previous bit across them.

A run of bytes at densities that do not divide evenly is checked cell by cell against a model with a fractional carry. This separates a correct carry from truncation or rounding. It also shows whether a new density starts on the right cell. Random bytes at random densities mix these cases. Very small densities check the one-cycle floor. Empty slots, a mid-byte disable and a re-enable that starts with a zero bit separate the underrun fill and the reset of the previous bit from normal encoding.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

    // Density value that stands for a cell of nominal width.
    localparam int DENS_UNIT = 1000;

    // Kind of raw cell that the encoder is producing.
    typedef enum logic [1:0] {
        CELL_OFF   = 2'd0,
        CELL_CLOCK = 2'd1,
        CELL_DATA  = 2'd2,
        CELL_GAP   = 2'd3
    } cell_state_e;

    // Bits needed to hold the longest possible cell length.
    function automatic int cell_len_bits(int dens_w, int nom_ticks);
        return $clog2((((2 ** dens_w) - 1) * nom_ticks) / DENS_UNIT + 2);
    endfunction

endpackage

// File: rtl/mfm_cell_timer.sv
module mfm_cell_timer
    import mfm_pkg::*;
#(
    parameter int NOM_TICKS = 250,
    parameter int DENS_W    = 11,
    localparam int LEN_W    = cell_len_bits(DENS_W, NOM_TICKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DENS_W-1:0] cell_dens,
    output logic              load,
    output logic              running,
    output logic [LEN_W-1:0]  phase
);

    localparam int REM_W = $clog2(DENS_UNIT);
    localparam int SUM_W = DENS_W + $clog2(NOM_TICKS + 1) + 1;

    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] phase_q;
    logic [REM_W-1:0] rem_q;
    logic             running_q;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] quot;
    logic [LEN_W-1:0] next_len;
    logic [REM_W-1:0] next_rem;

    // Scaled cell length with the carried fraction, floored at one tick.
    always_comb begin
        sum      = SUM_W'(cell_dens) * SUM_W'(NOM_TICKS) + SUM_W'(rem_q);
        quot     = sum / SUM_W'(DENS_UNIT);
        next_rem = REM_W'(sum % SUM_W'(DENS_UNIT));
        next_len = (quot == '0) ? LEN_W'(1) : LEN_W'(quot);
    end

    // A new cell is loaded on the first enabled cycle and at the end of each cell.
    assign load    = en && (!running_q || (left_q == LEN_W'(1)));
    assign running = running_q;
    assign phase   = phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            running_q <= 1'b0;
            left_q    <= '0;
            phase_q   <= '0;
            rem_q     <= '0;
        end else if (load) begin
            running_q <= 1'b1;
            left_q    <= next_len;
            phase_q   <= '0;
            rem_q     <= next_rem;
        end else begin
            left_q    <= left_q - LEN_W'(1);
            phase_q   <= phase_q + LEN_W'(1);
        end
    end

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (left_q != '0)); // R9

endmodule

// File: rtl/mfm_encoder.sv
module mfm_encoder
    import mfm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DENS_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DENS_W-1:0] in_dens,
    output logic              in_ready,
    output logic [DENS_W-1:0] cell_dens,
    output logic              cell_bit,
    output logic              underrun
);

    localparam int SLOT_W    = $clog2(2 * DATA_W);
    localparam int LAST_SLOT = 2 * DATA_W - 1;
    localparam int MSB       = DATA_W - 1;

    cell_state_e        state_q, state_d;
    logic [SLOT_W-1:0]  slot_q;
    logic [DATA_W-1:0]  shreg_q;
    logic [DENS_W-1:0]  dens_q;
    logic               prev_q;
    logic               bit_q;
    logic               under_q;
    logic               byte_end;
    logic               take;

    assign byte_end  = (state_q == CELL_OFF) || (slot_q == SLOT_W'(LAST_SLOT));
    assign in_ready  = load && byte_end;
    assign take      = in_ready && in_valid;
    assign cell_dens = take ? in_dens : dens_q;
    assign cell_bit  = bit_q;
    assign underrun  = under_q;

    // Next-state logic: start, bit half, next bit, byte boundary, stop.
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = CELL_OFF;
        end else if (load) begin
            if (byte_end) begin
                state_d = in_valid ? CELL_CLOCK : CELL_GAP;
            end else begin
                unique case (state_q)
                    CELL_CLOCK: state_d = CELL_DATA;
                    CELL_DATA:  state_d = CELL_CLOCK;
                    CELL_GAP:   state_d = CELL_GAP;
                    CELL_OFF:   state_d = CELL_CLOCK;
                endcase
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CELL_OFF;
        else        state_q <= state_d;
    end

    // Cell contents, byte shifter and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= '0;
            shreg_q <= '0;
            dens_q  <= DENS_W'(DENS_UNIT);
            prev_q  <= 1'b0;
            bit_q   <= 1'b0;
            under_q <= 1'b0;
        end else if (!en) begin
            slot_q  <= '0;
            prev_q  <= 1'b0;
            bit_q   <= 1'b0;
            under_q <= 1'b0;
        end else if (load) begin
            if (byte_end) begin
                slot_q <= '0;
                if (in_valid) begin
                    shreg_q <= in_data;
                    dens_q  <= in_dens;
                    bit_q   <= !prev_q && !in_data[MSB];
                end else begin
                    bit_q   <= 1'b0;
                    prev_q  <= 1'b0;
                    under_q <= 1'b1;
                end
            end else begin
                slot_q <= slot_q + SLOT_W'(1);
                case (state_q)
                    CELL_CLOCK: begin
                        bit_q  <= shreg_q[MSB];
                        prev_q <= shreg_q[MSB];
                    end
                    CELL_DATA: begin
                        shreg_q <= shreg_q << 1;
                        bit_q   <= !prev_q && !shreg_q[MSB-1];
                    end
                    default: bit_q <= 1'b0;
                endcase
            end
        end
    end

    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (under_q && en) |=> under_q); // R6

    AST_GAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CELL_GAP) |-> !bit_q); // R6

endmodule

// File: rtl/mfm_pulse_shaper.sv
module mfm_pulse_shaper #(
    parameter int PULSE_TICKS = 125,
    parameter int LEN_W       = 10
) (
    input  logic             running,
    input  logic [LEN_W-1:0] phase,
    input  logic             cell_bit,
    output logic             rd_n,
    output logic             cell_stb
);

    logic in_window;

    // The pulse window opens at the cell start; a short cell cuts it off.
    assign in_window = int'(phase) < PULSE_TICKS;
    assign cell_stb  = running && (phase == '0);
    assign rd_n      = !(running && cell_bit && in_window);

endmodule

// File: rtl/mfm_cell_gen.sv
module mfm_cell_gen
    import mfm_pkg::*;
#(
    parameter int NOM_TICKS   = 250,
    parameter int PULSE_TICKS = 125,
    parameter int DATA_W      = 8,
    parameter int DENS_W      = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DENS_W-1:0] in_dens,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              rd_n,
    output logic              cell_stb,
    output logic              underrun
);

    localparam int LEN_W = cell_len_bits(DENS_W, NOM_TICKS);

    logic              load;
    logic              running;
    logic [LEN_W-1:0]  phase;
    logic [DENS_W-1:0] cell_dens;
    logic              cell_bit;

    mfm_cell_timer #(
        .NOM_TICKS (NOM_TICKS),
        .DENS_W    (DENS_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cell_dens (cell_dens),
        .load      (load),
        .running   (running),
        .phase     (phase)
    );

    mfm_encoder #(
        .DATA_W    (DATA_W),
        .DENS_W    (DENS_W)
    ) u_encoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .load      (load),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_dens   (in_dens),
        .in_ready  (in_ready),
        .cell_dens (cell_dens),
        .cell_bit  (cell_bit),
        .underrun  (underrun)
    );

    mfm_pulse_shaper #(
        .PULSE_TICKS (PULSE_TICKS),
        .LEN_W       (LEN_W)
    ) u_shaper (
        .running  (running),
        .phase    (phase),
        .cell_bit (cell_bit),
        .rd_n     (rd_n),
        .cell_stb (cell_stb)
    );

    AST_PULSE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> cell_stb); // R4

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (rd_n && !cell_stb)); // R7

    AST_READY_THEN_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> cell_stb); // R5

    AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready); // R5

endmodule

// File: tb/mfm_cell_gen_test.sv
module mfm_cell_gen_test;

    localparam int NOM   = 20;
    localparam int PULSE = 5;
    localparam int DW    = 8;
    localparam int NW    = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [NW-1:0] in_dens = NW'(1000);
    logic          in_valid = 1'b0;
    logic          in_ready, rd_n, cell_stb, underrun;

    always #5 clk = ~clk;

    mfm_cell_gen #(.NOM_TICKS(NOM), .PULSE_TICKS(PULSE), .DATA_W(DW), .DENS_W(NW)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .in_data(in_data), .in_dens(in_dens),
        .in_valid(in_valid), .in_ready(in_ready), .rd_n(rd_n), .cell_stb(cell_stb),
        .underrun(underrun)
    );

    int errs = 0;
    int checks = 0;
    int exp_len [4096];
    bit exp_bit [4096];
    int exp_ltag[4096];
    int exp_btag[4096];
    int wr = 0;
    int rd = 0;
    int m_prev = 0;
    int m_rem = 0;
    int m_dens = 1000;
    bit cell_open = 0;
    int c_len = 0;
    int c_pw = 0;
    bit c_contig = 1;
    bit took = 0;

    function automatic string tag_name(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            6: return "R6";
            9: return "R9";
            default: return "R?";
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Expected cell from the length rule with fractional carry (R2, R9).
    task automatic push(bit b, int btag);
        int total, len;
        total = m_dens * NOM + m_rem;
        len = total / 1000;
        m_rem = total % 1000;
        if (len < 1) len = 1;
        exp_len[wr] = len;
        exp_bit[wr] = b;
        exp_btag[wr] = btag;
        exp_ltag[wr] = (m_dens == 1000) ? 1 : ((m_dens * NOM < 1000) ? 9 : 2);
        wr++;
    endtask

    task automatic book();
        if (in_valid) begin
            m_dens = int'(in_dens);
            for (int i = DW - 1; i >= 0; i--) begin
                bit b;
                b = in_data[i];
                push((m_prev == 0) && !b, 3);
                push(b, 3);
                m_prev = b ? 1 : 0;
            end
            took = 1;
        end else begin
            for (int i = 0; i < 2 * DW; i++) push(1'b0, 6);
            m_prev = 0;
        end
    endtask

    task automatic close_cell();
        int ew;
        if (rd >= wr) begin
            check(1'b0, "R5", rd, wr);
        end else begin
            check(c_len == exp_len[rd], tag_name(exp_ltag[rd]), c_len, exp_len[rd]);
            check((c_pw != 0) == exp_bit[rd], tag_name(exp_btag[rd]), int'(c_pw != 0), int'(exp_bit[rd]));
            ew = exp_bit[rd] ? ((PULSE < exp_len[rd]) ? PULSE : exp_len[rd]) : 0;
            check((c_pw == ew) && c_contig, "R4", c_pw, ew);
            rd++;
        end
    endtask

    task automatic sample();
        if (cell_stb) begin
            if (cell_open) close_cell();
            cell_open = 1;
            c_len = 1;
            c_pw = rd_n ? 0 : 1;
            c_contig = 1;
        end else if (cell_open) begin
            c_len++;
            if (!rd_n) begin
                if (c_pw == c_len - 1) c_pw++;
                else c_contig = 0;
            end
        end else begin
            check(rd_n, "R4", int'(rd_n), 1);
        end
        if (in_ready) begin
            check(cell_open ? (rd == wr - 1) : (rd == wr), "R5", rd, wr);
            book();
        end
    endtask

    // Inputs change only at the falling edge; sampling follows 1 ns later.
    task automatic tick();
        #1;
        sample();
        @(negedge clk);
    endtask

    task automatic send(logic [DW-1:0] d, int dens);
        in_data = d;
        in_dens = NW'(dens);
        in_valid = 1'b1;
        took = 0;
        while (!took) tick();
        in_valid = 1'b0;
    endtask

    task automatic off_for(int n);
        en = 1'b0;
        tick();
        rd = wr;
        cell_open = 0;
        m_prev = 0;
        m_rem = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            check(rd_n && !cell_stb && !in_ready && !underrun, "R7",
                  {rd_n, cell_stb, in_ready, underrun}, 4'b1000);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        #1;
        check(rd_n && !cell_stb && !in_ready && !underrun, "R8",
              {rd_n, cell_stb, in_ready, underrun}, 4'b1000);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        check(rd_n && !underrun, "R8", int'(rd_n), 1);

        // Empty slots right after reset: silent cells at the reset density.
        en = 1'b1;
        repeat (50) tick();
        check(underrun == 1'b1, "R6", int'(underrun), 1);

        // Nominal density, edge patterns for clock insertion.
        send(8'h00, 1000);
        send(8'hFF, 1000);
        send(8'hA5, 1000);
        send(8'h00, 1000);
        send(8'h80, 1000);
        send(8'h01, 1000);

        // Density changes inside the track, with uneven fractions.
        send(8'h5A, 1025);
        send(8'hC3, 975);
        send(8'h0F, 1500);
        send(8'h96, 600);
        send(8'h3E, 1001);
        send(8'h71, 1999);

        for (int i = 0; i < 40; i++) begin
            send(DW'($urandom % 256), 800 + int'($urandom % 401));
        end

        // Short gap inside the stream, then resume.
        repeat (400) tick();
        send(8'h24, 1000);
        send(8'hE7, 1010);
        check(underrun == 1'b1, "R6", int'(underrun), 1);

        // Tiny density: cells fall to the one-cycle floor.
        send(8'hB6, 30);
        send(8'h41, 30);
        send(8'h00, 30);
        send(8'h3C, 1000);
        repeat (40) tick();

        // Disable in the middle of a byte whose last bit was 1.
        send(8'hFF, 1000);
        repeat (150) tick();
        off_for(12);

        // Re-enable: a leading 0 bit must get a clock pulse.
        en = 1'b1;
        send(8'h00, 1000);
        send(8'h49, 990);
        check(underrun == 1'b0, "R7", int'(underrun), 0);
        send(8'h92, 1000);
        repeat (400) tick();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule